// File: doc/BRIEF.md
# LPC Host-Channel Register Decoder

This block is the slave-side register decode for one host-interface channel attached behind an LPC bus controller. The bus controller hands it one strobe per decoded I/O cycle, together with a 16-bit I/O address, a read/write flag and a write byte. The block compares the address against a programmable base and selects one of two windows derived from that base. The first is a keyboard-controller style data/status pair. The second is a bank of sixteen two-way bytes. One cycle after the strobe, the block reports whether it claimed the cycle and what read data it returns.

The data/status window holds an input data register loaded by the host and an output data register loaded by the local side. It also keeps a command/data flag and a status byte that carries the buffer-full flags. The two-way bank has a master-write byte at index 0 that the host writes. A host read of index 0 returns a slave-write byte that the local side writes. Indices 1 to 15 are shared bytes that the host can both read and write. The local side loads the base address and the two enable bits through a configuration strobe.

Top module: `lpc_host_chan`

## Requirements
- R1: After reset, every stored byte, flag, the base address and both enable bits are 0, so the block drives host_claim=0, host_rdata=0x00, loc_idr=0x00, loc_cd=0, loc_status=0x00 and loc_mw=0x00.
- R2: While the channel-enable bit is 0, no host cycle is claimed in either window, whatever the state of the two-way enable bit.
- R3: The data/status window matches when address bits 15..3 and bit 1 equal the base, and address bit 0 is 0. Base bit 0 is treated as 0 and address bit 2 is not compared.
- R4: A host write in the data/status window loads the write byte into the input register (loc_idr). It sets the command/data flag (loc_cd) to 0 when address bit 2 is 0, and to 1 when address bit 2 is 1.
- R5: A host read in the data/status window returns the output register when address bit 2 is 0 and the status byte when address bit 2 is 1. The value returned is the one held before that cycle.
- R6: The status byte has the command/data flag in bit 3, input-buffer-full in bit 1 and output-buffer-full in bit 0; all other bits are 0. A host write to the input register sets input-buffer-full, and a local read strobe clears it. If both happen in the same cycle, the set wins.
- R7: A local strobe that loads the output register sets output-buffer-full. A host read of the output register (address bit 2 = 0) clears it. If both happen in the same cycle, the set wins.
- R8: The two-way window matches when address bits 15..5 equal the base and address bit 4 differs from base bit 4. Bits 3..0 are not compared. It is gated by a separate two-way enable bit, and while that bit is 0 such cycles are not claimed.
- R9: In the two-way window, address bits 3..0 index a byte. A host write to index 0 loads the master-write byte (loc_mw), and a host read of index 0 returns the slave-write byte loaded by loc_sw_we. Indices 1..15 return what the host last wrote there.
- R10: host_claim is high for exactly the one cycle after each strobe that matched a window. Unclaimed cycles return host_rdata=0x00 and change no stored state. host_rdata is 0x00 after a claimed write.
- R11: A cycle with cfg_we high loads the base address, channel-enable and two-way enable from the cfg inputs. The new values first take effect for strobes in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_base | input | 16 | Base I/O address to load |
| cfg_chan_en | input | 1 | Channel-enable value to load |
| cfg_twr_en | input | 1 | Two-way enable value to load |
| host_stb | input | 1 | One-cycle strobe for a decoded LPC I/O cycle |
| host_wr | input | 1 | 1 = I/O write, 0 = I/O read |
| host_addr | input | 16 | I/O address of the cycle |
| host_wdata | input | 8 | Host write byte |
| host_claim | output | 1 | Cycle was claimed (one cycle after the strobe) |
| host_rdata | output | 8 | Read data, valid with host_claim |
| loc_odr_we | input | 1 | Local load of the output register |
| loc_odr_wdata | input | 8 | Byte for the output register |
| loc_idr_rd | input | 1 | Local read strobe; clears input-buffer-full |
| loc_sw_we | input | 1 | Local load of the slave-write byte |
| loc_sw_wdata | input | 8 | Byte for the slave-write byte |
| loc_idr | output | 8 | Input data register |
| loc_cd | output | 1 | Command/data flag |
| loc_status | output | 8 | Status byte |
| loc_mw | output | 8 | Master-write byte |

## Verification
Directed host cycles land on each address around the base. These include both data/status addresses, the address with bit 0 set, the address with bit 1 flipped, the first and last two-way index and an interior two-way index. This separates correct masking of each ignored bit from an over- or under-masked compare. The bench repeats the two-way accesses with the two-way enable off and with the channel enable off, which exposes any missing gate. It drives same-cycle collisions of a local load with a host read, and of a host write with a local read, to show which edge of each buffer-full flag takes priority. A random phase then mixes host reads and writes near the base with local strobes and enable changes. A behavioural model is compared with every output on every clock.

// File: rtl/lpc_hc_pkg.sv
package lpc_hc_pkg;
  typedef enum logic [1:0] {
    HC_SEL_NONE = 2'd0,
    HC_SEL_KBC  = 2'd1,
    HC_SEL_TWR  = 2'd2
  } hc_sel_e;

  localparam int unsigned HC_ST_OBF = 0;
  localparam int unsigned HC_ST_IBF = 1;
  localparam int unsigned HC_ST_CD  = 3;
  localparam int unsigned HC_SUB_BIT = 2;
endpackage

// File: rtl/hc_addr_match.sv
module hc_addr_match
  import lpc_hc_pkg::*;
#(
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned TWR_IW   = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic              chan_en,
  input  logic              twr_en,
  output hc_sel_e           sel,
  output logic              sub,
  output logic [TWR_IW-1:0] idx
);
  logic kbc_hit;
  logic twr_hit;

  always_comb begin
    kbc_hit = chan_en
            && (addr[ADDR_W-1:HC_SUB_BIT+1] == base[ADDR_W-1:HC_SUB_BIT+1])
            && (addr[1] == base[1])
            && !addr[0];
    twr_hit = chan_en && twr_en
            && (addr[ADDR_W-1:TWR_IW+1] == base[ADDR_W-1:TWR_IW+1])
            && (addr[TWR_IW] != base[TWR_IW]);
    if (kbc_hit)      sel = HC_SEL_KBC;
    else if (twr_hit) sel = HC_SEL_TWR;
    else              sel = HC_SEL_NONE;
    sub = addr[HC_SUB_BIT];
    idx = addr[TWR_IW-1:0];
  end
endmodule

// File: rtl/hc_kbc_regs.sv
module hc_kbc_regs #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic              host_odr_re,
  input  logic              sub,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              loc_odr_we,
  input  logic [DATA_W-1:0] loc_odr_wdata,
  input  logic              loc_idr_rd,
  output logic [DATA_W-1:0] idr,
  output logic [DATA_W-1:0] odr,
  output logic              cd,
  output logic              ibf,
  output logic              obf
);
  logic [DATA_W-1:0] idr_d, odr_d;
  logic              cd_d, ibf_d, obf_d;

  always_comb begin
    idr_d = idr;
    cd_d  = cd;
    odr_d = odr;
    if (host_we) begin
      idr_d = host_wdata;
      cd_d  = sub;
    end
    if (loc_odr_we) odr_d = loc_odr_wdata;
    ibf_d = host_we    | (ibf & ~loc_idr_rd);
    obf_d = loc_odr_we | (obf & ~host_odr_re);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idr <= '0;
      odr <= '0;
      cd  <= 1'b0;
      ibf <= 1'b0;
      obf <= 1'b0;
    end else begin
      idr <= idr_d;
      odr <= odr_d;
      cd  <= cd_d;
      ibf <= ibf_d;
      obf <= obf_d;
    end
  end
endmodule

// File: rtl/hc_twr_bank.sv
module hc_twr_bank #(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TWR_IW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_we,
  input  logic [TWR_IW-1:0] idx,
  input  logic [DATA_W-1:0] host_wdata,
  input  logic              loc_sw_we,
  input  logic [DATA_W-1:0] loc_sw_wdata,
  output logic [DATA_W-1:0] rd_byte,
  output logic [DATA_W-1:0] mw
);
  localparam int unsigned DEPTH = 1 << TWR_IW;

  logic [DEPTH-1:0][DATA_W-1:0] host_bytes;
  logic [DATA_W-1:0]            sw_q;
  logic [DATA_W-1:0]            sw_d;

  for (genvar g = 0; g < DEPTH; g++) begin : g_byte
    logic [DATA_W-1:0] byte_q;
    logic [DATA_W-1:0] byte_d;
    logic              byte_en;
    always_comb begin
      byte_en = host_we && (idx == TWR_IW'(g));
      byte_d  = byte_en ? host_wdata : byte_q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= '0;
      else        byte_q <= byte_d;
    end
    assign host_bytes[g] = byte_q;
  end

  always_comb sw_d = loc_sw_we ? loc_sw_wdata : sw_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= '0;
    else        sw_q <= sw_d;
  end

  assign mw      = host_bytes[0];
  assign rd_byte = (idx == '0) ? sw_q : host_bytes[idx];
endmodule

// File: rtl/lpc_host_chan.sv
module lpc_host_chan
  import lpc_hc_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  parameter int unsigned TWR_IW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              cfg_chan_en,
  input  logic              cfg_twr_en,
  input  logic              host_stb,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic              host_claim,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              loc_odr_we,
  input  logic [DATA_W-1:0] loc_odr_wdata,
  input  logic              loc_idr_rd,
  input  logic              loc_sw_we,
  input  logic [DATA_W-1:0] loc_sw_wdata,
  output logic [DATA_W-1:0] loc_idr,
  output logic              loc_cd,
  output logic [DATA_W-1:0] loc_status,
  output logic [DATA_W-1:0] loc_mw
);
  logic [ADDR_W-1:0] base_q, base_d;
  logic              chan_en_q, chan_en_d;
  logic              twr_en_q, twr_en_d;
  logic              claim_d;
  logic [DATA_W-1:0] rdata_d;

  hc_sel_e           sel;
  logic              sub;
  logic [TWR_IW-1:0] idx;
  logic              kbc_we, kbc_odr_re, twr_we;
  logic [DATA_W-1:0] odr, twr_rd;
  logic              ibf, obf;

  hc_addr_match #(.ADDR_W(ADDR_W), .TWR_IW(TWR_IW)) u_match (
    .addr    (host_addr),
    .base    (base_q),
    .chan_en (chan_en_q),
    .twr_en  (twr_en_q),
    .sel     (sel),
    .sub     (sub),
    .idx     (idx)
  );

  always_comb begin
    kbc_we     = host_stb &&  host_wr && (sel == HC_SEL_KBC);
    kbc_odr_re = host_stb && !host_wr && (sel == HC_SEL_KBC) && !sub;
    twr_we     = host_stb &&  host_wr && (sel == HC_SEL_TWR);
  end

  hc_kbc_regs #(.DATA_W(DATA_W)) u_kbc (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_we       (kbc_we),
    .host_odr_re   (kbc_odr_re),
    .sub           (sub),
    .host_wdata    (host_wdata),
    .loc_odr_we    (loc_odr_we),
    .loc_odr_wdata (loc_odr_wdata),
    .loc_idr_rd    (loc_idr_rd),
    .idr           (loc_idr),
    .odr           (odr),
    .cd            (loc_cd),
    .ibf           (ibf),
    .obf           (obf)
  );

  hc_twr_bank #(.DATA_W(DATA_W), .TWR_IW(TWR_IW)) u_twr (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_we      (twr_we),
    .idx          (idx),
    .host_wdata   (host_wdata),
    .loc_sw_we    (loc_sw_we),
    .loc_sw_wdata (loc_sw_wdata),
    .rd_byte      (twr_rd),
    .mw           (loc_mw)
  );

  always_comb begin
    loc_status            = '0;
    loc_status[HC_ST_CD]  = loc_cd;
    loc_status[HC_ST_IBF] = ibf;
    loc_status[HC_ST_OBF] = obf;
  end

  always_comb begin
    base_d    = cfg_we ? cfg_base    : base_q;
    chan_en_d = cfg_we ? cfg_chan_en : chan_en_q;
    twr_en_d  = cfg_we ? cfg_twr_en  : twr_en_q;
    claim_d   = host_stb && (sel != HC_SEL_NONE);
    rdata_d   = '0;
    if (host_stb && !host_wr) begin
      unique case (sel)
        HC_SEL_KBC: rdata_d = sub ? loc_status : odr;
        HC_SEL_TWR: rdata_d = twr_rd;
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q     <= '0;
      chan_en_q  <= 1'b0;
      twr_en_q   <= 1'b0;
      host_claim <= 1'b0;
      host_rdata <= '0;
    end else begin
      base_q     <= base_d;
      chan_en_q  <= chan_en_d;
      twr_en_q   <= twr_en_d;
      host_claim <= claim_d;
      host_rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/hc_chk.sv
module hc_chk #(
  parameter int unsigned DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              host_stb,
  input logic              host_claim,
  input logic [DATA_W-1:0] host_rdata,
  input logic              loc_odr_we,
  input logic              loc_idr_rd,
  input logic [DATA_W-1:0] loc_status,
  input logic              chan_en
);
  assert_claim_needs_stb_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_stb |=> !host_claim);

  assert_idle_rdata_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !host_claim |-> (host_rdata == '0));

  assert_disabled_no_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |=> !host_claim);

  assert_obf_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
    loc_odr_we |=> loc_status[0]);

  assert_ibf_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_idr_rd && !host_stb) |=> !loc_status[1]);

  assert_status_spare_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_status[DATA_W-1:4] == '0) && !loc_status[2]);
endmodule

bind lpc_host_chan hc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_stb   (host_stb),
  .host_claim (host_claim),
  .host_rdata (host_rdata),
  .loc_odr_we (loc_odr_we),
  .loc_idr_rd (loc_idr_rd),
  .loc_status (loc_status),
  .chan_en    (chan_en_q)
);

// File: tb/sim_lpc_host_chan.sv
`timescale 1ns/1ps
module sim_lpc_host_chan;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_base = '0;
  logic        cfg_chan_en = 1'b0, cfg_twr_en = 1'b0;
  logic        host_stb = 1'b0, host_wr = 1'b0;
  logic [15:0] host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_claim;
  logic [7:0]  host_rdata;
  logic        loc_odr_we = 1'b0, loc_idr_rd = 1'b0, loc_sw_we = 1'b0;
  logic [7:0]  loc_odr_wdata = '0, loc_sw_wdata = '0;
  logic [7:0]  loc_idr, loc_status, loc_mw;
  logic        loc_cd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  lpc_host_chan u0 (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .cfg_chan_en(cfg_chan_en), .cfg_twr_en(cfg_twr_en),
    .host_stb(host_stb), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_claim(host_claim), .host_rdata(host_rdata),
    .loc_odr_we(loc_odr_we), .loc_odr_wdata(loc_odr_wdata), .loc_idr_rd(loc_idr_rd),
    .loc_sw_we(loc_sw_we), .loc_sw_wdata(loc_sw_wdata), .loc_idr(loc_idr),
    .loc_cd(loc_cd), .loc_status(loc_status), .loc_mw(loc_mw)
  );

  // behavioural reference
  logic [15:0] m_base;
  bit          m_ce, m_te, m_cd, m_ibf, m_obf, m_claim;
  int          m_idr, m_odr, m_sw, m_rdata;
  int          m_tw [16];
  bit          hit_d, hit_t, set_i, clr_o;
  int          stat_now;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_base = 0; m_ce = 0; m_te = 0; m_cd = 0; m_ibf = 0; m_obf = 0;
      m_claim = 0; m_idr = 0; m_odr = 0; m_sw = 0; m_rdata = 0;
      foreach (m_tw[i]) m_tw[i] = 0;
    end else begin
      stat_now = m_cd * 8 + m_ibf * 2 + m_obf;
      hit_d = host_stb && m_ce && ((((host_addr ^ (m_base & 16'hFFFE)) & 16'hFFFB)) == 0);
      hit_t = host_stb && m_ce && m_te && ((((host_addr ^ (m_base ^ 16'h0010)) & 16'hFFF0)) == 0);
      set_i = 0; clr_o = 0;
      m_claim = hit_d || hit_t;
      m_rdata = 0;
      if (hit_d) begin
        if (host_wr) begin
          m_idr = host_wdata; m_cd = host_addr[2]; set_i = 1;
        end else if (host_addr[2]) m_rdata = stat_now;
        else begin
          m_rdata = m_odr; clr_o = 1;
        end
      end
      if (hit_t) begin
        if (host_wr) m_tw[host_addr[3:0]] = host_wdata;
        else m_rdata = (host_addr[3:0] == 0) ? m_sw : m_tw[host_addr[3:0]];
      end
      m_ibf = set_i || (m_ibf && !loc_idr_rd);
      m_obf = loc_odr_we || (m_obf && !clr_o);
      if (loc_odr_we) m_odr = loc_odr_wdata;
      if (loc_sw_we)  m_sw  = loc_sw_wdata;
      if (cfg_we) begin
        m_base = cfg_base; m_ce = cfg_chan_en; m_te = cfg_twr_en;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #2;
    if (!done) begin
      check("R10 claim", host_claim, m_claim);
      check("R5 rdata", host_rdata, m_rdata);
      check("R4 idr", loc_idr, m_idr);
      check("R4 cd", loc_cd, m_cd);
      check("R6 status", loc_status, m_cd * 8 + m_ibf * 2 + m_obf);
      check("R9 mw", loc_mw, m_tw[0]);
    end
  end

  task automatic cfg(input logic [15:0] b, input bit ce, input bit te);
    @(negedge clk);
    cfg_we = 1; cfg_base = b; cfg_chan_en = ce; cfg_twr_en = te;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic host_op(input bit wr, input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_stb = 1; host_wr = wr; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_stb = 0;
  endtask

  task automatic loc_op(input bit odr_we, input logic [7:0] od, input bit idr_rd,
                        input bit sw_we, input logic [7:0] sd);
    @(negedge clk);
    loc_odr_we = odr_we; loc_odr_wdata = od; loc_idr_rd = idr_rd;
    loc_sw_we = sw_we; loc_sw_wdata = sd;
    @(negedge clk);
    loc_odr_we = 0; loc_idr_rd = 0; loc_sw_we = 0;
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog expired");
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 claim", host_claim, 0);
    check("R1 status", loc_status, 0);
    check("R1 idr", loc_idr, 0);
    check("R1 mw", loc_mw, 0);

    // base stored but channel off
    cfg(16'h0063, 0, 1);
    host_op(1, 16'h0062, 8'h77);
    check("R2 no claim", host_claim, 0);
    check("R2 idr unchanged", loc_idr, 0);
    host_op(1, 16'h0071, 8'h77);
    check("R2 twr no claim", host_claim, 0);

    cfg(16'h0063, 1, 0);
    host_op(1, 16'h0062, 8'hA5);
    check("R11 claim after cfg", host_claim, 1);
    check("R4 idr", loc_idr, 8'hA5);
    check("R4 cd0", loc_cd, 0);
    check("R6 ibf set", loc_status, 8'h02);
    host_op(1, 16'h0066, 8'h3C);
    check("R4 cd1", loc_cd, 1);
    check("R6 status cd", loc_status, 8'h0A);
    host_op(1, 16'h0063, 8'hEE);
    check("R3 bit0 no claim", host_claim, 0);
    check("R10 no state change", loc_idr, 8'h3C);
    host_op(0, 16'h0060, 8'h00);
    check("R3 bit1 no claim", host_claim, 0);
    host_op(0, 16'h0070, 8'h00);
    check("R8 twr gated", host_claim, 0);
    check("R10 rdata zero", host_rdata, 0);

    loc_op(0, 0, 1, 0, 0);
    check("R6 ibf clear", loc_status, 8'h08);
    loc_op(1, 8'h5A, 0, 0, 0);
    check("R7 obf set", loc_status, 8'h09);
    host_op(0, 16'h0066, 8'h00);
    check("R5 status read", host_rdata, 8'h09);
    host_op(0, 16'h0062, 8'h00);
    check("R5 odr read", host_rdata, 8'h5A);
    check("R7 obf clear", loc_status, 8'h08);

    // collisions
    @(negedge clk);
    host_stb = 1; host_wr = 0; host_addr = 16'h0062; loc_odr_we = 1; loc_odr_wdata = 8'hC3;
    @(negedge clk);
    host_stb = 0; loc_odr_we = 0;
    check("R7 set wins", loc_status[0], 1);
    check("R5 old odr", host_rdata, 8'h5A);
    @(negedge clk);
    host_stb = 1; host_wr = 1; host_addr = 16'h0066; host_wdata = 8'h44; loc_idr_rd = 1;
    @(negedge clk);
    host_stb = 0; loc_idr_rd = 0;
    check("R6 set wins", loc_status[1], 1);

    cfg(16'h0063, 1, 1);
    host_op(1, 16'h0070, 8'h11);
    check("R9 mw write", loc_mw, 8'h11);
    check("R8 twr claim", host_claim, 1);
    loc_op(0, 0, 0, 1, 8'h22);
    host_op(0, 16'h0070, 8'h00);
    check("R9 idx0 reads sw", host_rdata, 8'h22);
    host_op(1, 16'h007F, 8'h99);
    host_op(0, 16'h007F, 8'h00);
    check("R9 idx15", host_rdata, 8'h99);
    host_op(0, 16'h0075, 8'h00);
    check("R9 idx5 empty", host_rdata, 8'h00);
    host_op(1, 16'h0068, 8'h55);
    check("R8 bit4 equal no claim", host_claim, 0);
    host_op(0, 16'h0170, 8'h00);
    check("R8 upper bit no claim", host_claim, 0);

    // random mix near the base
    for (int n = 0; n < 3000; n++) begin
      @(negedge clk);
      host_stb = ($urandom % 3) != 0;
      host_wr = $urandom % 2;
      host_addr = {7'h00, 1'($urandom % 8 == 0), 8'h60 + 8'($urandom % 32)};
      host_wdata = 8'($urandom);
      loc_odr_we = ($urandom % 5) == 0; loc_odr_wdata = 8'($urandom);
      loc_idr_rd = ($urandom % 5) == 0;
      loc_sw_we = ($urandom % 7) == 0; loc_sw_wdata = 8'($urandom);
      cfg_we = ($urandom % 50) == 0;
      cfg_base = ($urandom % 2) ? 16'h0063 : 16'h0070;
      cfg_chan_en = ($urandom % 6) != 0; cfg_twr_en = $urandom % 2;
    end
    @(negedge clk);
    host_stb = 0; loc_odr_we = 0; loc_idr_rd = 0; loc_sw_we = 0; cfg_we = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule